// File: doc/BRIEF.md
# I2C Controller Status, Interrupt and Bit-Clock Prescaler

This block is the register-side companion of a multi-master I2C controller. It holds the control byte, the own slave address and the receive data register, along with the status flags that software polls or takes interrupts on. It also contains the prescaler that turns the bus clock into a master bit-rate tick. A separate serial byte engine, not part of this block, reports three kinds of event: a byte has arrived (with a marker if that byte was a calling address), the transmit byte has been taken for shifting, and a new transfer has begun.

A CPU reaches the block through a plain register port with read, write, a 2-bit address and 8-bit data. Reads are combinational. The status flags are cleared by writing 0 to them. When the module is disabled, every flag is held clear. A received byte is only accepted into the receive register while that register is empty. Software frees the register by reading it.

Register layout: address 0 is control, with enable at bit 7, interrupt enable at bit 6, extended match at bit 5, master mode at bit 4 and baud code at bits 2:0. Address 1 is status, with receive flag at bit 7, transmit flag at bit 6, address match at bit 5 and receive-full at bit 0. Address 2 is the own 7-bit address at bits 6:0. Address 3 is receive data.

Top module: `i2c_stat_ctl`

## Requirements
- R1: While control bit 7 and bit 4 are both 1, `master_tick` is high for exactly one clock in every 8·2^n clocks, where n is the baud code in control bits 2:0 (000 gives 8, 111 gives 1024). While either bit is 0, the tick stays low.
- R2: After reset, control (address 0) and status (address 1) read 0x00, and `irq` and `master_tick` are low.
- R3: When enabled and the receive register is empty, an `ev_rx_byte` pulse stores `ev_rx_data` and sets status bit 7 (receive flag) and bit 0 (receive full).
- R4: While status bit 0 is 1, an arriving byte is dropped and the receive register keeps its contents. A CPU read of address 3 clears bit 0 so that the next byte is accepted.
- R5: When enabled, an `ev_tx_taken` pulse sets status bit 6 (transmit flag).
- R6: Writing status with bit 7 or bit 6 at 0 clears the corresponding flag, and writing 1 leaves it unchanged. A set event in the same cycle as a clearing write wins.
- R7: While control bit 7 is 0, status reads 0x00 and events set nothing.
- R8: `irq` is high exactly when control bit 6 is 1 and status bit 7 or bit 6 is 1.
- R9: An arriving byte marked by `ev_rx_is_addr` sets status bit 5 when its bits 7:1 equal the own address.
- R10: With control bit 5 at 1, the address match also ignores the lowest own-address bit, so both addresses of that pair match.
- R11: An `ev_xfer_start` pulse clears status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | CPU write strobe |
| reg_rd | input | 1 | CPU read strobe (side effect on address 3) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | CPU read data, combinational |
| ev_rx_byte | input | 1 | Byte engine delivered a byte |
| ev_rx_data | input | 8 | Delivered byte |
| ev_rx_is_addr | input | 1 | Delivered byte is a calling address |
| ev_tx_taken | input | 1 | Transmit byte moved to the shifter |
| ev_xfer_start | input | 1 | A new transfer has begun |
| irq | output | 1 | Interrupt request |
| master_tick | output | 1 | Master bit-rate enable pulse |

## Verification
Every register write and every event takes effect at the clock edge on which it is held. Status, data, `irq` and read data therefore change one edge after the stimulus. The bench drives on the falling edge and samples either after the following rising edge or at the next falling edge, so each sample falls in the first cycle the new value is valid. The prescaler is judged by counting whole clocks between two successive tick pulses, never from the moment of the write. One further falling edge after a tick confirms that the tick lasted one clock.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
   localparam int REG_AW   = 2;
   localparam int REG_DW   = 8;
   localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
   localparam logic [REG_AW-1:0] A_STAT = 2'd1;
   localparam logic [REG_AW-1:0] A_OWN  = 2'd2;
   localparam logic [REG_AW-1:0] A_DATA = 2'd3;
   // control bit positions
   localparam int C_EN  = 7;
   localparam int C_IE  = 6;
   localparam int C_EXT = 5;
   localparam int C_MST = 4;
   // status bit positions
   localparam int S_RXF  = 7;
   localparam int S_TXF  = 6;
   localparam int S_MAT  = 5;
   localparam int S_FULL = 0;
endpackage

// File: rtl/i2c_flag_cell.sv
module i2c_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic force_clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           q_o <= 1'b0;
      else if (force_clr_i) q_o <= 1'b0;
      else if (set_i)       q_o <= 1'b1;
      else if (clr_i)       q_o <= 1'b0;
   end

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !force_clr_i) |=> q_o);
   // R7
   forced_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_clr_i |=> !q_o);
   // R6
   clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
   parameter int ADDR_W   = 7,
   parameter int EXT_LSBS = 1
) (
   input  logic [ADDR_W-1:0] cand_i,
   input  logic [ADDR_W-1:0] own_i,
   input  logic              ext_en_i,
   output logic              hit_o
);
   if (ADDR_W < 2) begin : g_bad_w
      $error("i2c_addr_cmp: ADDR_W must be at least 2");
   end
   if (EXT_LSBS < 0 || EXT_LSBS >= ADDR_W) begin : g_bad_ext
      $error("i2c_addr_cmp: EXT_LSBS out of range");
   end

   logic [ADDR_W-1:0] care;
   for (genvar i = 0; i < ADDR_W; i++) begin : g_care
      if (i < EXT_LSBS) begin : g_soft
         assign care[i] = ~ext_en_i;
      end else begin : g_hard
         assign care[i] = 1'b1;
      end
   end

   assign hit_o = ((cand_i ^ own_i) & care) == '0;
endmodule

// File: rtl/i2c_baud_div.sv
module i2c_baud_div #(
   parameter int SEL_W     = 3,
   parameter int BASE_LOG2 = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int MAX_LOG2 = BASE_LOG2 + (1 << SEL_W) - 1;
   localparam int CNT_W    = MAX_LOG2;

   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("i2c_baud_div: BASE_LOG2 must be at least 1");
   end
   if (SEL_W < 1 || MAX_LOG2 > 30) begin : g_bad_sel
      $error("i2c_baud_div: SEL_W out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   always_comb begin
      lim = CNT_W'((32'd1 << (BASE_LOG2 + int'(sel_i))) - 32'd1);
   end

   assign tick_o = run_i && (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // R1
   tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
   // R1
   idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/i2c_stat_ctl.sv
module i2c_stat_ctl
   import i2c_stat_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int EXT_LSBS  = 1,
   parameter int SEL_W     = 3,
   parameter int BASE_LOG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic              ev_rx_byte,
   input  logic [REG_DW-1:0] ev_rx_data,
   input  logic              ev_rx_is_addr,
   input  logic              ev_tx_taken,
   input  logic              ev_xfer_start,
   output logic              irq,
   output logic              master_tick
);
   if (ADDR_W + 1 != REG_DW) begin : g_bad_aw
      $error("i2c_stat_ctl: address plus direction bit must fill a data byte");
   end
   if (SEL_W > 4) begin : g_bad_sel
      $error("i2c_stat_ctl: baud code must fit below the mode bits");
   end

   logic [REG_DW-1:0] ctrl_q;
   logic [ADDR_W-1:0] own_q;
   logic [REG_DW-1:0] rx_data_q;
   logic rxf, txf, mat, full;
   logic en, addr_hit, load, wr_stat, rd_data;

   assign en      = ctrl_q[C_EN];
   assign wr_stat = reg_wr && (reg_addr == A_STAT);
   assign rd_data = reg_rd && (reg_addr == A_DATA);
   assign load    = en && ev_rx_byte && !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         own_q     <= '0;
         rx_data_q <= '0;
      end else begin
         if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata;
         if (reg_wr && reg_addr == A_OWN)  own_q  <= reg_wdata[ADDR_W-1:0];
         if (load)                         rx_data_q <= ev_rx_data;
      end
   end

   i2c_addr_cmp #(.ADDR_W(ADDR_W), .EXT_LSBS(EXT_LSBS)) u_cmp (
      .cand_i  (ev_rx_data[REG_DW-1:1]),
      .own_i   (own_q),
      .ext_en_i(ctrl_q[C_EXT]),
      .hit_o   (addr_hit)
   );

   i2c_flag_cell u_rxf (.clk(clk), .rst_n(rst_n), .set_i(load),
      .clr_i(wr_stat && !reg_wdata[S_RXF]), .force_clr_i(!en), .q_o(rxf));
   i2c_flag_cell u_txf (.clk(clk), .rst_n(rst_n), .set_i(en && ev_tx_taken),
      .clr_i(wr_stat && !reg_wdata[S_TXF]), .force_clr_i(!en), .q_o(txf));
   i2c_flag_cell u_mat (.clk(clk), .rst_n(rst_n),
      .set_i(en && ev_rx_byte && ev_rx_is_addr && addr_hit),
      .clr_i(ev_xfer_start), .force_clr_i(!en), .q_o(mat));
   i2c_flag_cell u_full (.clk(clk), .rst_n(rst_n), .set_i(load),
      .clr_i(rd_data), .force_clr_i(!en), .q_o(full));

   i2c_baud_div #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (en && ctrl_q[C_MST]),
      .sel_i (ctrl_q[SEL_W-1:0]),
      .tick_o(master_tick)
   );

   assign irq = ctrl_q[C_IE] && (rxf || txf);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: reg_rdata = ctrl_q;
         A_STAT: begin
            reg_rdata[S_RXF]  = rxf;
            reg_rdata[S_TXF]  = txf;
            reg_rdata[S_MAT]  = mat;
            reg_rdata[S_FULL] = full;
         end
         A_OWN:  reg_rdata = {1'b0, own_q};
         default: reg_rdata = rx_data_q;
      endcase
   end

   // R4
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && ev_rx_byte) |=> $stable(rx_data_q));
   // R3
   rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ev_rx_byte && !full) |=> (full && rx_data_q == $past(ev_rx_data)));
   // R7
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !(rxf || txf || mat || full));
endmodule

// File: tb/i2c_stat_ctl_bench.sv
module i2c_stat_ctl_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       ev_rx_byte = 1'b0, ev_rx_is_addr = 1'b0;
   logic [7:0] ev_rx_data = '0;
   logic       ev_tx_taken = 1'b0, ev_xfer_start = 1'b0;
   logic       irq, master_tick;
   int         n_run = 0, n_fail = 0;
   logic       done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_stat_ctl u_i2c_stat_ctl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_rx_byte(ev_rx_byte), .ev_rx_data(ev_rx_data),
      .ev_rx_is_addr(ev_rx_is_addr), .ev_tx_taken(ev_tx_taken),
      .ev_xfer_start(ev_xfer_start), .irq(irq), .master_tick(master_tick)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic rx_byte(input logic [7:0] d, input logic is_addr);
      @(negedge clk);
      ev_rx_byte = 1'b1; ev_rx_data = d; ev_rx_is_addr = is_addr;
      @(negedge clk);
      ev_rx_byte = 1'b0; ev_rx_is_addr = 1'b0;
   endtask

   task automatic tx_taken();
      @(negedge clk); ev_tx_taken = 1'b1;
      @(negedge clk); ev_tx_taken = 1'b0;
   endtask

   task automatic xfer_start();
      @(negedge clk); ev_xfer_start = 1'b1;
      @(negedge clk); ev_xfer_start = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(2'd0, v); chk("R2 ctrl", v, 8'h00);
      rd(2'd1, v); chk("R2 stat", v, 8'h00);
      chk("R2 irq", irq, 0);
      chk("R2 tick", master_tick, 0);
   endtask

   task automatic t_receive();
      logic [7:0] v;
      wr(2'd0, 8'hC0);
      rx_byte(8'h5A, 1'b0);
      rd(2'd1, v); chk("R3 stat after byte", v, 8'h81);
      chk("R8 irq with rx flag", irq, 1);
      rx_byte(8'h33, 1'b0);
      rd(2'd3, v); chk("R4 second byte dropped", v, 8'h5A);
      rd(2'd1, v); chk("R4 full cleared by read", v, 8'h80);
      rx_byte(8'h77, 1'b0);
      rd(2'd3, v); chk("R4 load resumes", v, 8'h77);
   endtask

   task automatic t_clear();
      logic [7:0] v;
      wr(2'd1, 8'hFF);
      rd(2'd1, v); chk("R6 write one keeps flag", v, 8'h80);
      wr(2'd1, 8'h00);
      rd(2'd1, v); chk("R6 write zero clears", v, 8'h00);
      chk("R8 irq low", irq, 0);
      tx_taken();
      rd(2'd1, v); chk("R5 tx flag", v, 8'h40);
      wr(2'd1, 8'h80);
      rd(2'd1, v); chk("R6 clear tx only", v, 8'h00);
      @(negedge clk);
      ev_tx_taken = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h00;
      @(negedge clk);
      ev_tx_taken = 1'b0; reg_wr = 1'b0;
      rd(2'd1, v); chk("R6 set beats clear", v, 8'h40);
      wr(2'd0, 8'h80);
      chk("R8 irq masked", irq, 0);
      wr(2'd0, 8'hC0);
      chk("R8 irq unmasked", irq, 1);
   endtask

   task automatic t_match();
      logic [7:0] v;
      wr(2'd0, 8'h80);
      wr(2'd2, 8'h2C);
      rx_byte(8'h58, 1'b1);
      rd(2'd1, v); chk("R9 exact match", v & 8'h20, 8'h20);
      xfer_start();
      rd(2'd1, v); chk("R11 cleared by start", v & 8'h20, 8'h00);
      rx_byte(8'h5A, 1'b1);
      rd(2'd1, v); chk("R9 neighbour rejected", v & 8'h20, 8'h00);
      rx_byte(8'h58, 1'b0);
      rd(2'd1, v); chk("R9 data byte ignored", v & 8'h20, 8'h00);
      wr(2'd0, 8'hA0);
      rx_byte(8'h5A, 1'b1);
      rd(2'd1, v); chk("R10 extended pair", v & 8'h20, 8'h20);
      xfer_start();
      rx_byte(8'h5C, 1'b1);
      rd(2'd1, v); chk("R10 outside pair", v & 8'h20, 8'h00);
   endtask

   task automatic t_disable();
      logic [7:0] v;
      wr(2'd0, 8'hA0);
      tx_taken();
      rx_byte(8'h5A, 1'b1);
      rd(2'd1, v); chk("R7 flags set before", v & 8'h60, 8'h60);
      wr(2'd0, 8'h00);
      rd(2'd1, v); chk("R7 cleared on disable", v, 8'h00);
      tx_taken();
      rx_byte(8'h11, 1'b0);
      rd(2'd1, v); chk("R7 events ignored", v, 8'h00);
      wr(2'd0, 8'h80);
      rd(2'd1, v); chk("R7 stays clear on enable", v, 8'h00);
   endtask

   task automatic t_baud();
      for (int code = 0; code < 8; code++) begin
         int exp_p = 8 << code;
         int p = 0;
         int guard = 0;
         wr(2'd0, 8'h90 | code[7:0]);
         while (master_tick !== 1'b1 && guard < 3000) begin
            @(negedge clk); guard++;
         end
         @(negedge clk);
         chk("R1 tick one clock wide", master_tick, 0);
         p = 1;
         while (master_tick !== 1'b1 && p < 3000) begin
            @(negedge clk); p++;
         end
         chk($sformatf("R1 period code %0d", code), p, exp_p);
      end
      wr(2'd0, 8'h80);
      begin
         int seen = 0;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (master_tick) seen++;
         end
         chk("R1 no tick outside master", seen, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_receive();
      t_clear();
      t_match();
      t_disable();
      t_baud();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule